// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and takes the memory from power-up to normal operation. It idles with the clock enable low and chip select deasserted. It waits for a start input that reports stable supplies and a stable clock. It then holds off for a power-up delay, measured in clock cycles and derived from a clock-frequency parameter and a delay in microseconds. After that it drives a fixed series of commands on the memory command bus and finally raises a done flag.

The series is fixed. A NOP raises the clock enable, and a precharge of all banks follows. Next come a write to the extended mode register that enables the DLL and a write to the base mode register that resets the DLL. A second precharge of all banks follows, then two auto refresh commands. A final base mode register write leaves the DLL-reset bit clear. Each command is followed by a parameterized minimum gap, filled with NOP. The done flag also waits for a DLL lock window that is counted from the DLL-reset write. The mode register word is assembled from field parameters, and the extended word is a parameter.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is low, and afterwards until `start_i` is sampled high, `cke_o` is 0, the command pins {cs_n,ras_n,cas_n,we_n} are 1111 (DESELECT), `ba_o` and `addr_o` are 0, and `init_done_o` is 0.
- R2: Let the power-up wait be P = CLK_MHZ*PWRUP_US cycles. `cke_o` rises together with the first NOP exactly P+1 clock edges after the edge that samples `start_i` high. Any value on `start_i` after that edge has no effect.
- R3: Command pin encoding {cs_n,ras_n,cas_n,we_n}: NOP 0111, PRECHARGE 0010, LOAD MODE 0000, AUTO REFRESH 0001. Every cycle from the first NOP onward that carries no sequence command drives NOP with `cke_o` high.
- R4: The commands appear in this order: NOP, PRECHARGE, LOAD MODE (extended), LOAD MODE (base, DLL reset), PRECHARGE, AUTO REFRESH, AUTO REFRESH, LOAD MODE (base, final).
- R5: Each PRECHARGE drives `addr_o[10]`=1, all other address bits 0 and `ba_o`=00, so that all banks close.
- R6: The extended mode write drives `ba_o`=01 and `addr_o`=EMR_VAL. Bit 0 of that word is low, which enables the DLL.
- R7: Each base mode write drives `ba_o`=00 and `addr_o` = {OP_MODE, CAS_LAT, BURST_TYPE, BURST_LEN}, which places the fields at bits 13:7, 6:4, 3 and 2:0. Bit 8 is forced to 1 in the DLL-reset write and to 0 in the final write.
- R8: The next command follows exactly G cycles after the previous one. G is 2 after the NOP, T_RP after a PRECHARGE, T_MRD after a LOAD MODE and T_RFC after an AUTO REFRESH, each raised to at least 2.
- R9: `init_done_o` rises at the later of two edges: T_MRD cycles after the final mode write, and DLL_LOCK cycles after the DLL-reset write.
- R10: Once high, `init_done_o` and `cke_o` stay high until reset. After the sequence ends the bus carries NOP. Reset is asynchronous and returns the outputs to the R1 state at any point of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Supplies and clock stable; begins the sequence |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Initialization complete |

## Verification
Every output is registered, so a command planned for a step is visible one edge after the step is entered. The bench takes the edge that samples `start_i` as time zero. From it and the parameters, bench functions give the exact edge of each command, of the rise of `cke_o` and of `init_done_o`. These are P+1 edges for the first NOP, then the sum of the clamped gaps, and the later of the two completion bounds for done. All outputs are sampled on the falling edge after every rising edge and compared with these expected values, so a command one cycle early or late fails. Resets asserted in the middle of the sequence are checked half a cycle later, because the reset is asynchronous.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  localparam int BA_W = 2;
  localparam int AP_BIT = 10;
  localparam int DLL_RST_BIT = 8;

  typedef enum logic [2:0] {
    CMD_DESEL, CMD_NOP, CMD_PRE, CMD_LMR, CMD_REF
  } cmd_e;

  // order of the command steps is the command order
  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_NOP, ST_PRE1, ST_EMR, ST_MRR,
    ST_PRE2, ST_REF1, ST_REF2, ST_MR, ST_LOCK, ST_DONE
  } state_e;
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_cmd_enc.sv
module ddr_cmd_enc
  import ddr_init_pkg::*;
(
  input  cmd_e cmd_i,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_NOP: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
      CMD_PRE: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0010;
      CMD_LMR: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0000;
      CMD_REF: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0001;
      default: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b1111;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int CLK_MHZ  = 100,
  parameter int PWRUP_US = 200,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 10,
  parameter int DLL_LOCK = 200,
  parameter logic [2:0]        BURST_LEN  = 3'b010,
  parameter logic              BURST_TYPE = 1'b0,
  parameter logic [2:0]        CAS_LAT    = 3'b010,
  parameter logic [ADDR_W-8:0] OP_MODE    = '0,
  parameter logic [ADDR_W-1:0] EMR_VAL    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);
  localparam int PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int G_NOP = 2;
  localparam int G_RP  = (T_RP  < 2) ? 2 : T_RP;
  localparam int G_MRD = (T_MRD < 2) ? 2 : T_MRD;
  localparam int G_RFC = (T_RFC < 2) ? 2 : T_RFC;
  localparam int M1 = (G_RP > G_MRD) ? G_RP : G_MRD;
  localparam int M2 = (M1 > G_RFC) ? M1 : G_RFC;
  localparam int MAXV = (PWR_CYC > M2) ? PWR_CYC : M2;
  localparam int TW = $clog2(MAXV + 1);
  localparam int LW = $clog2(DLL_LOCK + 1);
  localparam logic [ADDR_W-1:0] MR_WORD = {OP_MODE, CAS_LAT, BURST_TYPE, BURST_LEN};
  localparam logic [ADDR_W-1:0] DLL_BIT = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  state_e state_q, state_d;
  logic   wait_q, wait_d;
  cmd_e   cmd_q, cmd_d;
  logic   cke_q, cke_d, done_q, done_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic          tmr_load, tmr_zero, lock_load, lock_zero;
  logic [TW-1:0] tmr_val;

  cmd_e              s_cmd;
  int                s_gap;
  logic [BA_W-1:0]   s_ba;
  logic [ADDR_W-1:0] s_addr;

  // per-step command, bank, address and following gap
  always_comb begin
    s_cmd = CMD_NOP; s_gap = G_NOP; s_ba = '0; s_addr = '0;
    case (state_q)
      ST_PRE1, ST_PRE2: begin s_cmd = CMD_PRE; s_gap = G_RP; s_addr = AP_MASK; end
      ST_EMR:  begin s_cmd = CMD_LMR; s_gap = G_MRD; s_ba = 2'b01; s_addr = EMR_VAL; end
      ST_MRR:  begin s_cmd = CMD_LMR; s_gap = G_MRD; s_addr = MR_WORD | DLL_BIT; end
      ST_REF1, ST_REF2: begin s_cmd = CMD_REF; s_gap = G_RFC; end
      ST_MR:   begin s_cmd = CMD_LMR; s_gap = G_MRD; s_addr = MR_WORD & ~DLL_BIT; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q; wait_d = wait_q;
    cmd_d = cke_q ? CMD_NOP : CMD_DESEL;
    cke_d = cke_q; done_d = done_q; ba_d = '0; addr_d = '0;
    tmr_load = 1'b0; tmr_val = '0; lock_load = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PWR; tmr_load = 1'b1; tmr_val = TW'(PWR_CYC - 1);
      end
      ST_PWR:  if (tmr_zero) state_d = ST_NOP;
      ST_LOCK: if (lock_zero) begin state_d = ST_DONE; done_d = 1'b1; end
      ST_DONE: ;
      default: begin
        if (!wait_q) begin
          cmd_d = s_cmd; ba_d = s_ba; addr_d = s_addr;
          tmr_load = 1'b1; tmr_val = TW'(s_gap - 2); wait_d = 1'b1;
          if (state_q == ST_NOP) cke_d = 1'b1;
          if (state_q == ST_MRR) lock_load = 1'b1;
        end else if (tmr_zero) begin
          state_d = state_e'(state_q + 1'b1); wait_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; wait_q <= 1'b0; cmd_q <= CMD_DESEL;
      cke_q <= 1'b0; done_q <= 1'b0; ba_q <= '0; addr_q <= '0;
    end else begin
      state_q <= state_d; wait_q <= wait_d; cmd_q <= cmd_d;
      cke_q <= cke_d; done_q <= done_d; ba_q <= ba_d; addr_q <= addr_d;
    end
  end

  ddr_init_timer #(.W(TW)) u_gap_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  ddr_init_timer #(.W(LW)) u_lock_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lock_load),
    .val_i(LW'(DLL_LOCK - 1)), .zero_o(lock_zero)
  );

  ddr_cmd_enc u_enc (
    .cmd_i(cmd_q), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o)
  );

  assign cke_o       = cke_q;
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign init_done_o = done_q;

  logic [3:0] pins;
  assign pins = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  p_desel_cke_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (pins == 4'b1111));
  p_cke_rise_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (pins == 4'b0111));
  p_pre_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0010) |-> (addr_o[AP_BIT] && ba_o == 2'b00));
  p_lmr_bank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0000) |-> !ba_o[1]);
  p_cmd_then_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && pins != 4'b0111) |=> (pins == 4'b0111));
  p_done_after_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> lock_zero);
  p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  p_cke_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int CLK_MHZ = 1, PWRUP_US = 50;
  localparam int T_RP = 3, T_MRD = 2, T_RFC = 7, DLL_LOCK = 40;
  localparam logic [2:0] BL = 3'b010, CL = 3'b011;
  localparam logic BT = 1'b1;
  localparam logic [6:0] OPM = 7'h00;
  localparam logic [13:0] EMRV = 14'h0002;

  localparam int P = CLK_MHZ * PWRUP_US;
  localparam int GRP = (T_RP < 2) ? 2 : T_RP;
  localparam int GMRD = (T_MRD < 2) ? 2 : T_MRD;
  localparam int GRFC = (T_RFC < 2) ? 2 : T_RFC;
  localparam int O_NOP = P + 1;
  localparam int O_PRE1 = O_NOP + 2;
  localparam int O_EMR = O_PRE1 + GRP;
  localparam int O_MRR = O_EMR + GMRD;
  localparam int O_PRE2 = O_MRR + GMRD;
  localparam int O_REF1 = O_PRE2 + GRP;
  localparam int O_REF2 = O_REF1 + GRFC;
  localparam int O_MR = O_REF2 + GRFC;
  localparam int O_DONE = ((O_MR + GMRD) > (O_MRR + DLL_LOCK)) ? (O_MR + GMRD) : (O_MRR + DLL_LOCK);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, init_done_o;
  logic [1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;
  int cyc = 0, errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .DLL_LOCK(DLL_LOCK), .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL),
    .OP_MODE(OPM), .EMR_VAL(EMRV)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cke_o(cke_o), .cs_n_o(cs_n_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o),
    .init_done_o(init_done_o)
  );

  function automatic logic [13:0] mr_word();
    return 14'((int'(OPM) << 7) | (int'(CL) << 4) | (int'(BT) << 3) | int'(BL));
  endfunction

  function automatic logic [3:0] exp_pins(int rel);
    if (rel < O_NOP) return 4'b1111;
    if (rel == O_PRE1 || rel == O_PRE2) return 4'b0010;
    if (rel == O_EMR || rel == O_MRR || rel == O_MR) return 4'b0000;
    if (rel == O_REF1 || rel == O_REF2) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic logic [1:0] exp_ba(int rel);
    return (rel == O_EMR) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [13:0] exp_addr(int rel);
    if (rel == O_PRE1 || rel == O_PRE2) return 14'h0400;
    if (rel == O_EMR) return EMRV;
    if (rel == O_MRR) return mr_word() | 14'h0100;
    if (rel == O_MR) return mr_word() & ~14'h0100;
    return 14'h0;
  endfunction

  function automatic string tag_of(int rel);
    if (rel < 0) return "R1";
    if (rel <= O_NOP) return "R2";
    if (rel == O_PRE1 || rel == O_PRE2) return "R5";
    if (rel == O_EMR) return "R6";
    if (rel == O_MRR || rel == O_MR) return "R7";
    if (rel == O_REF1 || rel == O_REF2) return "R4 R8";
    if (rel > O_DONE) return "R10";
    return "R3";
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic check_at(int rel);
    logic [3:0] p;
    string t;
    p = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    t = tag_of(rel);
    chk(p == exp_pins(rel), t, "pins", p, exp_pins(rel));
    chk(cke_o == (rel >= O_NOP), (rel > O_DONE) ? "R10" : "R2", "cke", cke_o, rel >= O_NOP);
    chk(ba_o == exp_ba(rel), t, "ba", ba_o, exp_ba(rel));
    chk(addr_o == exp_addr(rel), t, "addr", addr_o, exp_addr(rel));
    chk(init_done_o == (rel >= O_DONE), (rel > O_DONE) ? "R10" : "R9", "done",
        init_done_o, rel >= O_DONE);
  endtask

  task automatic check_reset(string req);
    chk(cke_o == 1'b0, req, "rst cke", cke_o, 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b1111, req, "rst pins",
        {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'hf);
    chk(init_done_o == 1'b0, req, "rst done", init_done_o, 0);
    chk(ba_o == 2'b00 && addr_o == '0, req, "rst bus", addr_o, 0);
  endtask

  // abort_at < 0 runs to completion; otherwise reset is pulled mid-sequence
  task automatic run_seq(int abort_at);
    int s;
    @(negedge clk); rst_ni = 1'b0; start_i = 1'b0;
    #1 check_reset("R1");
    @(negedge clk); rst_ni = 1'b1;
    repeat ($urandom_range(0, 15)) begin
      @(negedge clk); check_at(-1);
    end
    start_i = 1'b1;
    s = cyc + 1;
    forever begin
      @(negedge clk);
      check_at(cyc - s);
      start_i = 1'($urandom_range(0, 1));
      if (abort_at >= 0 && cyc - s == abort_at) begin
        rst_ni = 1'b0;
        #1 check_reset("R10");
        break;
      end
      if (cyc - s >= O_DONE + 5) break;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    run_seq(-1);
    run_seq(O_MRR + 3);
    run_seq(-1);
    run_seq(int'($urandom_range(1, O_DONE + 2)));
    run_seq(O_NOP);
    run_seq(-1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule